// File: doc/BRIEF.md
# Serial Transceiver with Register Interface

This block is a single-channel asynchronous serial port seen by software as four word-wide registers on a simple synchronous read/write bus. On the transmit side, a character written to the data register goes into a one-entry holding stage. From there it is passed to a shift stage that drives the serial output. Each of the two stages reports its own empty flag, so software can tell "room for another character" apart from "line fully idle".

On the receive side, the block oversamples the serial input, reassembles a character into a holding register and reports data ready. It also reports four error conditions: overrun, parity mismatch, missing stop bit and a line held low for a whole frame.

Control bits switch receiver and transmitter on, pick interrupt causes, enable and select parity, enable CTS/RTS flow control and fold the transmitter back onto the receiver for self-test. A scaler register sets the bit rate. A single interrupt output pulses for both directions.

Top module: `sio_channel`

## Requirements
- R1: After reset the status register reads 0x06 (both transmit stages empty, no data, no errors), the control register reads 0x00, `txd` is high and `irq` is low.
- R2: Bus address bits [3:2] select the register: 0 data, 1 status, 2 control, 3 scaler (byte offsets 0x0, 0x4, 0x8, 0xC). Control keeps write-data bits [7:0] and scaler keeps bits [SCALER_W-1:0], and both read back what was written with zeros above.
- R3: An oversampling tick occurs every scaler+1 clocks and one serial bit lasts OVS (8) ticks, so one bit lasts 8*(scaler+1) clocks.
- R4: With control bit 1 (transmit enable) set, a character is sent as a low start bit, 8 data bits least significant first, an optional parity bit and a high stop bit. An idle transmitter holds its line high.
- R5: Writing the data register clears status bit 2 (holding empty). When the shift stage is free the character moves there, bit 2 is set again and status bit 1 (shift empty) stays clear until the stop bit has been sent.
- R6: Control bit 5 enables parity and control bit 4 selects its sense (1 odd, 0 even). The transmitter appends the parity bit, and a received parity bit that does not match sets status bit 5.
- R7: With control bit 0 set, a received character sets status bit 0 and appears in data bits [7:0], and a read of the data register clears bit 0. With control bit 0 clear, activity on the line is ignored.
- R8: A character that completes while status bit 0 is still set sets status bit 4 (overrun) and replaces the held character.
- R9: A character whose stop bit is sampled low, with data not all zero, sets status bit 6 and is still delivered.
- R10: A frame that is low from start through stop sets status bit 3, delivers no character, and the receiver starts no new frame until the line has returned high.
- R11: Writing the status register clears each of error bits 3 to 6 whose written bit is 0 and keeps those written as 1.
- R12: With control bit 6 set, no frame starts while `cts_n` is high, and `rts_n` is high exactly while status bit 0 is set. With bit 6 clear, `rts_n` is low.
- R13: With control bit 7 set, the transmitter output feeds the receiver, `rxd` is ignored and `txd` stays high.
- R14: `irq` pulses for one clock when a character is received with control bit 2 set, or when the holding stage empties with control bit 3 set, and it does not pulse for a cause whose enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 ([3:2]) | Register word select |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data of the selected register |
| irq | output | 1 | Combined receive/transmit interrupt pulse |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The transmitter is tried with an asymmetric pattern (0xA5) at one rate and with a parity-extended character at a slower rate. This separates bit ordering, bit length and parity sense. The receiver gets a clean character, two back-to-back characters with no read between, a wrong parity bit, a low stop bit and an all-low frame, so each error flag is seen raised alone. Loopback runs with `rxd` held low, which tells internal routing apart from the external pin. Flow control is held off and then released, and interrupt causes are tried with their enables both set and cleared.

// File: rtl/sio_pkg.sv
package sio_pkg;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_STAT = 2'd1,
      REG_CTRL = 2'd2,
      REG_SCAL = 2'd3
   } reg_sel_e;

   // control word, bit 7 first
   typedef struct packed {
      logic loop;
      logic flow;
      logic par_en;
      logic par_odd;
      logic tx_irq;
      logic rx_irq;
      logic tx_en;
      logic rx_en;
   } ctrl_t;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
   parameter int SCALER_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SCALER_W-1:0] scaler,
   output logic                tick
);

   if (SCALER_W < 2) begin : g_bad_width
      $error("sio_baud: SCALER_W must be at least 2");
   end

   logic [SCALER_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt == '0)    cnt <= scaler;
      else                   cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && scaler != '0) |=> !tick); // R3

endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
   parameter int OVS    = 8,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              tx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              cts_ok,
   input  logic              wr_char,
   input  logic [CHAR_W-1:0] wdata,
   output logic              line,
   output logic              thr_empty,
   output logic              tsr_empty,
   output logic              thr_drained
);

   localparam int SUB_W   = $clog2(OVS);
   localparam int FRAME_W = CHAR_W + 3;
   localparam int BIT_W   = $clog2(FRAME_W + 1);

   logic [CHAR_W-1:0]  thr;
   logic [FRAME_W-1:0] shreg;
   logic [BIT_W-1:0]   bits_left;
   logic [SUB_W-1:0]   sub;
   logic               load;
   logic               par_bit;

   assign load    = !thr_empty && tsr_empty && tx_en && cts_ok;
   assign par_bit = par_en ? (^thr ^ par_odd) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr       <= '0;
         thr_empty <= 1'b1;
      end else if (wr_char) begin
         thr       <= wdata;
         thr_empty <= 1'b0;
      end else if (load) begin
         thr_empty <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '1;
         bits_left <= '0;
         sub       <= '0;
         tsr_empty <= 1'b1;
      end else if (load) begin
         shreg     <= {1'b1, par_bit, thr, 1'b0};
         bits_left <= par_en ? BIT_W'(FRAME_W) : BIT_W'(FRAME_W - 1);
         sub       <= '0;
         tsr_empty <= 1'b0;
      end else if (!tsr_empty && tick) begin
         if (sub == SUB_W'(OVS - 1)) begin
            sub       <= '0;
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BIT_W'(1)) tsr_empty <= 1'b1;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assign line        = shreg[0];
   assign thr_drained = load;

   AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      tsr_empty |-> line); // R4

   AST_TX_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_empty) |-> $past(tx_en && cts_ok && tsr_empty)); // R12

   AST_TX_BUSY_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_empty) |-> !tsr_empty); // R5

endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int OVS         = 8,
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              line_in,
   input  logic              rd_char,
   input  logic              stat_wr,
   input  logic [3:0]        keep,
   output logic [CHAR_W-1:0] rbr,
   output logic              dr,
   output logic              brk,
   output logic              ovr,
   output logic              perr,
   output logic              ferr,
   output logic              got_char
);

   localparam int SUB_W = $clog2(OVS);
   localparam int HALF  = OVS / 2;
   localparam int IDX_W = $clog2(CHAR_W);

   logic line_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = line_in;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= 1'b1;
         else        sr <= line_in;
      end
      assign line_s = sr;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= {sr[SYNC_STAGES-2:0], line_in};
      end
      assign line_s = sr[SYNC_STAGES-1];
   end

   rx_state_e         st;
   logic [SUB_W-1:0]  sub;
   logic [IDX_W-1:0]  idx;
   logic [CHAR_W-1:0] shf;
   logic              par_bit;
   logic              done;
   logic              is_break;
   logic              par_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         sub     <= '0;
         idx     <= '0;
         shf     <= '0;
         par_bit <= 1'b0;
      end else begin
         case (st)
            RX_IDLE: begin
               if (rx_en && tick && !line_s) begin
                  st  <= RX_START;
                  sub <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (sub == SUB_W'(HALF - 1)) begin
                     sub <= '0;
                     idx <= '0;
                     st  <= line_s ? RX_IDLE : RX_DATA;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (sub == SUB_W'(OVS - 1)) begin
                     sub <= '0;
                     shf <= {line_s, shf[CHAR_W-1:1]};
                     idx <= idx + 1'b1;
                     if (idx == IDX_W'(CHAR_W - 1)) st <= par_en ? RX_PAR : RX_STOP;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            RX_PAR: begin
               if (tick) begin
                  if (sub == SUB_W'(OVS - 1)) begin
                     sub     <= '0;
                     par_bit <= line_s;
                     st      <= RX_STOP;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (sub == SUB_W'(OVS - 1)) begin
                     sub <= '0;
                     st  <= line_s ? RX_IDLE : RX_HOLD;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            RX_HOLD: begin
               if (line_s) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   assign done     = (st == RX_STOP) && tick && (sub == SUB_W'(OVS - 1));
   assign is_break = !line_s && (shf == '0) && !(par_en && par_bit);
   assign got_char = done && !is_break;
   assign par_bad  = par_en && (par_bit != (^shf ^ par_odd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbr  <= '0;
         dr   <= 1'b0;
         brk  <= 1'b0;
         ovr  <= 1'b0;
         perr <= 1'b0;
         ferr <= 1'b0;
      end else begin
         if (got_char) rbr <= shf;
         if (got_char)     dr <= 1'b1;
         else if (rd_char) dr <= 1'b0;
         brk  <= (done && is_break)   || (brk  && !(stat_wr && !keep[0]));
         ovr  <= (got_char && dr)     || (ovr  && !(stat_wr && !keep[1]));
         perr <= (got_char && par_bad)|| (perr && !(stat_wr && !keep[2]));
         ferr <= (got_char && !line_s)|| (ferr && !(stat_wr && !keep[3]));
      end
   end

   AST_OVR_NEEDS_DR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(dr)); // R8

   AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && !rx_en) |=> (st == RX_IDLE)); // R7

   AST_BRK_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk) |-> $stable(rbr)); // R10

endmodule

// File: rtl/sio_channel.sv
module sio_channel
   import sio_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int SCALER_W    = 12,
   parameter int OVS         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [3:2]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq,
   input  logic             rxd,
   output logic             txd,
   input  logic             cts_n,
   output logic             rts_n
);

   localparam int CHAR_W = 8;

   if (BUS_W < CHAR_W || SCALER_W > BUS_W) begin : g_bad_bus
      $error("sio_channel: BUS_W must hold 8 bits and the scaler");
   end
   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("sio_channel: OVS must be a power of two, at least 4");
   end

   reg_sel_e            sel;
   ctrl_t               ctrl;
   logic [SCALER_W-1:0] scaler;
   logic                wr_data, wr_stat, wr_ctrl, wr_scal, rd_data;
   logic                tick, cts_ok;
   logic                tx_line, rx_line;
   logic                thr_empty, tsr_empty, thr_drained;
   logic [CHAR_W-1:0]   rbr;
   logic                dr, brk, ovr, perr, ferr, got_char;
   logic [6:0]          status;
   logic                unused_wbits;

   assign sel     = reg_sel_e'(bus_addr);
   assign wr_data = bus_sel &&  bus_wr && sel == REG_DATA;
   assign wr_stat = bus_sel &&  bus_wr && sel == REG_STAT;
   assign wr_ctrl = bus_sel &&  bus_wr && sel == REG_CTRL;
   assign wr_scal = bus_sel &&  bus_wr && sel == REG_SCAL;
   assign rd_data = bus_sel && !bus_wr && sel == REG_DATA;
   assign unused_wbits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         scaler <= '0;
      end else begin
         if (wr_ctrl) ctrl   <= ctrl_t'(bus_wdata[CHAR_W-1:0]);
         if (wr_scal) scaler <= bus_wdata[SCALER_W-1:0];
      end
   end

   sio_baud #(.SCALER_W(SCALER_W)) u_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .scaler (scaler),
      .tick   (tick)
   );

   assign cts_ok = !ctrl.flow || !cts_n;

   sio_tx #(.OVS(OVS), .CHAR_W(CHAR_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .tx_en       (ctrl.tx_en),
      .par_en      (ctrl.par_en),
      .par_odd     (ctrl.par_odd),
      .cts_ok      (cts_ok),
      .wr_char     (wr_data),
      .wdata       (bus_wdata[CHAR_W-1:0]),
      .line        (tx_line),
      .thr_empty   (thr_empty),
      .tsr_empty   (tsr_empty),
      .thr_drained (thr_drained)
   );

   assign rx_line = ctrl.loop ? tx_line : rxd;
   assign txd     = ctrl.loop ? 1'b1 : tx_line;

   sio_rx #(.OVS(OVS), .CHAR_W(CHAR_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rx_en    (ctrl.rx_en),
      .par_en   (ctrl.par_en),
      .par_odd  (ctrl.par_odd),
      .line_in  (rx_line),
      .rd_char  (rd_data),
      .stat_wr  (wr_stat),
      .keep     (bus_wdata[6:3]),
      .rbr      (rbr),
      .dr       (dr),
      .brk      (brk),
      .ovr      (ovr),
      .perr     (perr),
      .ferr     (ferr),
      .got_char (got_char)
   );

   assign status = {ferr, perr, ovr, brk, thr_empty, tsr_empty, dr};
   assign rts_n  = ctrl.flow ? dr : 1'b0;

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_DATA: bus_rdata[CHAR_W-1:0]   = rbr;
         REG_STAT: bus_rdata[6:0]          = status;
         REG_CTRL: bus_rdata[CHAR_W-1:0]   = ctrl;
         REG_SCAL: bus_rdata[SCALER_W-1:0] = scaler;
         default:  bus_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (got_char && ctrl.rx_irq) || (thr_drained && ctrl.tx_irq);
   end

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ctrl.rx_irq || ctrl.tx_irq)); // R14

   AST_RTS_FOLLOWS_DR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.flow && $rose(dr)) |-> rts_n); // R12

endmodule

// File: tb/sio_channel_test.sv
`timescale 1ns/1ps
module sio_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        rxd = 1'b1;
   logic        txd;
   logic        cts_n = 1'b0;
   logic        rts_n;

   int n_checks = 0;
   int n_fail   = 0;
   int irq_cnt  = 0;

   always #2.5 clk = ~clk;

   sio_channel uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq),
      .rxd       (rxd),
      .txd       (txd),
      .cts_n     (cts_n),
      .rts_n     (rts_n)
   );

   always @(negedge clk) if (irq === 1'b1) irq_cnt++;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic send_frame(logic [7:0] d, bit use_par, bit par_val, bit stop_val, int per);
      rxd = 1'b0; wait_clk(per);
      for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_clk(per); end
      if (use_par) begin rxd = par_val; wait_clk(per); end
      rxd = stop_val; wait_clk(per);
      rxd = 1'b1;
   endtask

   task automatic capture(int per, int nbits, output logic [10:0] f);
      int guard = 0;
      f = '1;
      while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
      chk("R4 start bit seen", 32'(guard < 4000), 32'd1);
      wait_clk(per / 2);
      f[0] = txd;
      for (int i = 1; i < nbits; i++) begin wait_clk(per); f[i] = txd; end
   endtask

   task automatic t_reset();
      logic [31:0] r;
      bus_read(2'd1, r); chk("R1 status after reset", r, 32'h06);
      bus_read(2'd2, r); chk("R1 control after reset", r, 32'h00);
      chk("R1 txd idle", 32'(txd), 32'd1);
      chk("R1 irq low", 32'(irq_cnt), 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] r;
      bus_write(2'd2, 32'hFFFF_FF5A); bus_read(2'd2, r); chk("R2 control readback", r, 32'h5A);
      bus_write(2'd2, 32'h0);
      bus_write(2'd3, 32'h0001_2ABC); bus_read(2'd3, r); chk("R2 scaler readback", r, 32'hABC);
      bus_write(2'd3, 32'd1);
      wait_clk(8192);
   endtask

   task automatic t_tx_basic();
      logic [10:0] f;
      logic [31:0] r;
      bus_write(2'd2, 32'h02);
      fork
         capture(16, 10, f);
         begin bus_write(2'd0, 32'hA5); bus_read(2'd1, r); end
      join
      chk("R5 holding empty, shifter busy", r, 32'h04);
      chk("R4 R3 frame 0xA5", 32'(f[9:0]), 32'({1'b1, 8'hA5, 1'b0}));
      wait_clk(24);
      bus_read(2'd1, r); chk("R5 both stages empty", r, 32'h06);
   endtask

   task automatic t_tx_parity();
      logic [10:0] f;
      bus_write(2'd3, 32'd3);
      wait_clk(8);
      bus_write(2'd2, 32'h32);
      fork
         capture(32, 11, f);
         bus_write(2'd0, 32'h07);
      join
      chk("R6 R3 odd parity frame", 32'(f), 32'({1'b1, 1'b0, 8'h07, 1'b0}));
      wait_clk(48);
      bus_write(2'd3, 32'd1);
      wait_clk(8);
   endtask

   task automatic t_rx_basic();
      logic [31:0] r;
      bus_write(2'd2, 32'h01);
      send_frame(8'hC3, 0, 0, 1, 16); wait_clk(20);
      bus_read(2'd1, r); chk("R7 data ready", r, 32'h07);
      bus_read(2'd0, r); chk("R7 received char", r, 32'hC3);
      bus_read(2'd1, r); chk("R7 read clears ready", r, 32'h06);
      bus_write(2'd2, 32'h00);
      send_frame(8'h55, 0, 0, 1, 16); wait_clk(20);
      bus_read(2'd1, r); chk("R7 disabled receiver ignores line", r, 32'h06);
   endtask

   task automatic t_overrun();
      logic [31:0] r;
      bus_write(2'd2, 32'h01);
      send_frame(8'h11, 0, 0, 1, 16); wait_clk(4);
      send_frame(8'h22, 0, 0, 1, 16); wait_clk(20);
      bus_read(2'd1, r); chk("R8 overrun flag", r, 32'h17);
      bus_read(2'd0, r); chk("R8 newest char kept", r, 32'h22);
      bus_write(2'd1, 32'h0);
      bus_read(2'd1, r); chk("R11 write zero clears", r, 32'h06);
      send_frame(8'h33, 0, 0, 1, 16); wait_clk(4);
      send_frame(8'h44, 0, 0, 1, 16); wait_clk(20);
      bus_write(2'd1, 32'h10);
      bus_read(2'd1, r); chk("R11 write one keeps", r, 32'h17);
      bus_read(2'd0, r);
      bus_write(2'd1, 32'h0);
   endtask

   task automatic t_rx_parity();
      logic [31:0] r;
      bus_write(2'd2, 32'h21);
      send_frame(8'h5A, 1, 0, 1, 16); wait_clk(20);
      bus_read(2'd1, r); chk("R6 good even parity", r, 32'h07);
      bus_read(2'd0, r);
      send_frame(8'h5A, 1, 1, 1, 16); wait_clk(20);
      bus_read(2'd1, r); chk("R6 parity error flag", r, 32'h27);
      bus_read(2'd0, r);
      bus_write(2'd1, 32'h0);
   endtask

   task automatic t_framing();
      logic [31:0] r;
      bus_write(2'd2, 32'h01);
      send_frame(8'h3C, 0, 0, 0, 16); wait_clk(20);
      bus_read(2'd1, r); chk("R9 framing flag", r, 32'h47);
      bus_read(2'd0, r); chk("R9 char delivered", r, 32'h3C);
      bus_write(2'd1, 32'h0);
   endtask

   task automatic t_break();
      logic [31:0] r;
      rxd = 1'b0; wait_clk(12 * 16); rxd = 1'b1; wait_clk(40);
      bus_read(2'd1, r); chk("R10 break flag, no char", r, 32'h0E);
      bus_write(2'd1, 32'h0);
      send_frame(8'h81, 0, 0, 1, 16); wait_clk(20);
      bus_read(2'd0, r); chk("R10 receiver recovers", r, 32'h81);
   endtask

   task automatic t_loopback();
      logic [31:0] r;
      int lows = 0;
      bus_write(2'd2, 32'h83);
      rxd = 1'b0;
      fork
         bus_write(2'd0, 32'h96);
         for (int i = 0; i < 220; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      join
      bus_read(2'd1, r); chk("R13 loopback char ready", r, 32'h07);
      bus_read(2'd0, r); chk("R13 loopback char", r, 32'h96);
      chk("R13 txd held high", 32'(lows), 32'd0);
      rxd = 1'b1;
      wait_clk(4);
      bus_write(2'd2, 32'h00);
   endtask

   task automatic t_flow();
      logic [10:0] f;
      logic [31:0] r;
      bus_write(2'd2, 32'h42);
      cts_n = 1'b1;
      bus_write(2'd0, 32'h3E);
      wait_clk(100);
      bus_read(2'd1, r); chk("R12 held while cts_n high", r, 32'h02);
      chk("R12 line idle while held", 32'(txd), 32'd1);
      fork
         capture(16, 10, f);
         begin wait_clk(3); cts_n = 1'b0; end
      join
      chk("R12 frame after release", 32'(f[9:0]), 32'({1'b1, 8'h3E, 1'b0}));
      wait_clk(24);
      bus_write(2'd2, 32'h41);
      chk("R12 rts_n low when empty", 32'(rts_n), 32'd0);
      send_frame(8'h12, 0, 0, 1, 16); wait_clk(20);
      chk("R12 rts_n high with data", 32'(rts_n), 32'd1);
      bus_read(2'd0, r);
      chk("R12 rts_n low after read", 32'(rts_n), 32'd0);
      bus_write(2'd2, 32'h00);
   endtask

   task automatic t_irq();
      logic [31:0] r;
      int base;
      bus_write(2'd2, 32'h05);
      base = irq_cnt;
      send_frame(8'h77, 0, 0, 1, 16); wait_clk(20);
      chk("R14 receive interrupt", 32'(irq_cnt - base), 32'd1);
      bus_read(2'd0, r);
      bus_write(2'd2, 32'h01);
      base = irq_cnt;
      send_frame(8'h78, 0, 0, 1, 16); wait_clk(20);
      chk("R14 no interrupt when disabled", 32'(irq_cnt - base), 32'd0);
      bus_read(2'd0, r);
      bus_write(2'd2, 32'h0A);
      base = irq_cnt;
      bus_write(2'd0, 32'h01);
      wait_clk(200);
      chk("R14 transmit interrupt", 32'(irq_cnt - base), 32'd1);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_regs();
      t_tx_basic();
      t_tx_parity();
      t_rx_basic();
      t_overrun();
      t_rx_parity();
      t_framing();
      t_break();
      t_loopback();
      t_flow();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule